// File: doc/BRIEF.md
# Comparator Output Conditioning Filter

This block cleans up the single raw bit coming out of an analog comparator before any other logic acts on it. The raw bit can first pass through a two-stage synchronizer. It is then qualified by one of several digital filter behaviours, timed by a programmable cycle count, and can finally be inverted. Every control is a static input, and the block has no bus interface of its own.

There are four filter behaviours. The first follows an input change at once and then ignores the input for a hold-off period. The second lets a new level through only after the input has held it for a whole count. The last two qualify only one direction, falling or rising, and pass the other direction at once. A bypass input, the reserved mode codes and a count of zero all route the comparator bit around the filter. Dropping the enable clears the whole path.

Top module: `cmp_filter`

## Requirements
- R1: While `en` is 0, `out_o` is 0 whatever the other inputs are. At the first clock edge with `en` low, the synchronizer, the filtered level and the cycle counter are all cleared, so re-enabling starts from a filtered level of 0.
- R2: With `sync_en` set, the raw bit is sampled by two flops before it is used, so a change on `raw_in` reaches a bypassed output after the second clock edge. With `sync_en` clear, the raw bit is used directly and combinationally.
- R3: When `invert` is 1, the final output is the complement of the filtered or bypassed level. The complement is applied after filtering. It is not applied while the block is disabled.
- R4: When `bypass` is 1, the output is the (optionally synchronized) comparator bit in every filter mode.
- R5: Mode codes 3'b000 to 3'b011 and a `flt_len` of 0 both select bypass behaviour, whatever the mode.
- R6: Mode 3'b100 (immediate with hold-off): when the source differs from the filtered level, the filtered level takes the source at the next edge. It then ignores the source for the following `flt_len` edges.
- R7: Mode 3'b101 (qualified change): the filtered level takes a new value at the edge where the source has differed from it for `flt_len` consecutive edges. An edge on which the source matches the filtered level restarts the count.
- R8: Mode 3'b110 (qualify low): a rise of the source passes at the next edge. A fall passes only after `flt_len` consecutive edges of 0.
- R9: Mode 3'b111 (qualify high): a fall of the source passes at the next edge. A rise passes only after `flt_len` consecutive edges of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Comparator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables the whole path |
| raw_in | input | 1 | Raw comparator bit |
| bypass | input | 1 | Routes around the filter |
| invert | input | 1 | Inverts the final output |
| sync_en | input | 1 | Selects the two-flop synchronizer |
| mode | input | 3 | Filter behaviour code |
| flt_len | input | LEN_W | Filter length in clock cycles |
| out_o | output | 1 | Conditioned comparator output |

## Verification
The bench builds the block with the default 12-bit length field. It programs lengths of 1, 3 and 4 cycles, so that hold-off windows, glitch restarts and one-sided qualification all finish within a few dozen edges. It also uses a length of 0 to reach the bypass-by-length case. A per-edge reference model, derived from the requirements, feeds an expected-value queue, and this lets every mode be checked against both the synchronized and the direct source.

// File: rtl/cmp_filter.sv
module cmp_filter #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             raw_in,
  input  logic             bypass,
  input  logic             invert,
  input  logic             sync_en,
  input  logic [2:0]       mode,
  input  logic [LEN_W-1:0] flt_len,
  output logic             out_o
);

  logic             s1, s2, filt;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W:0]   cnt_inc;
  logic             src, eff_byp, fast_pass;

  assign src       = sync_en ? s2 : raw_in;
  assign eff_byp   = bypass | ~mode[2] | (flt_len == '0);
  assign fast_pass = (mode[1:0] == 2'b10 && src) || (mode[1:0] == 2'b11 && !src);
  assign cnt_inc   = {1'b0, cnt} + {{LEN_W{1'b0}}, 1'b1};
  assign out_o     = en & ((eff_byp ? src : filt) ^ invert);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; filt <= 1'b0; cnt <= '0;
    end else if (!en) begin
      s1 <= 1'b0; s2 <= 1'b0; filt <= 1'b0; cnt <= '0;
    end else begin
      s1 <= raw_in;
      s2 <= s1;
      if (eff_byp) begin
        filt <= src;
        cnt  <= '0;
      end else if (mode[1:0] == 2'b00) begin
        if (cnt != '0) cnt <= cnt - 1'b1;
        else if (src != filt) begin
          filt <= src;
          cnt  <= flt_len;
        end
      end else begin
        if (src == filt) cnt <= '0;
        else if (fast_pass) begin
          filt <= src;
          cnt  <= '0;
        end else if (cnt_inc >= {1'b0, flt_len}) begin
          filt <= src;
          cnt  <= '0;
        end else cnt <= cnt_inc[LEN_W-1:0];
      end
    end
  end

endmodule

module cmp_filter_chk #(
  parameter int LEN_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             bypass,
  input logic             invert,
  input logic [2:0]       mode,
  input logic [LEN_W-1:0] flt_len,
  input logic             src,
  input logic             filt,
  input logic [LEN_W-1:0] cnt,
  input logic             out_o
);

  a_r1_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !out_o);

  a_r1_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!filt && cnt == '0));

  a_r4_bypass_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bypass) |-> (out_o == (src ^ invert)));

  a_r7_match_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bypass && mode == 3'b101 && flt_len != '0 && src == filt) |=> $stable(filt));

  a_r8_rise_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bypass && mode == 3'b110 && flt_len != '0 && src && !filt) |=> filt);

  a_r9_fall_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bypass && mode == 3'b111 && flt_len != '0 && !src && filt) |=> !filt);

endmodule

bind cmp_filter cmp_filter_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .bypass(bypass), .invert(invert),
  .mode(mode), .flt_len(flt_len), .src(src), .filt(filt), .cnt(cnt),
  .out_o(out_o)
);

// File: tb/tb_cmp_filter.sv
module tb_cmp_filter;
  localparam int LEN_W = 12;

  logic clk = 1'b0;
  logic rst_n, en, raw_in, bypass, invert, sync_en;
  logic [2:0] mode;
  logic [LEN_W-1:0] flt_len;
  logic out_o;

  always #2 clk = ~clk;

  cmp_filter #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .raw_in(raw_in), .bypass(bypass),
    .invert(invert), .sync_en(sync_en), .mode(mode), .flt_len(flt_len),
    .out_o(out_o)
  );

  int n_run = 0, n_fail = 0;
  bit    exp_q[$];
  string tag_q[$];
  event  chk_ev;

  bit ms1 = 0, ms2 = 0, mf = 0;
  int mc = 0;

  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_run++;
        if (out_o !== e) begin
          n_fail++;
          $display("FAIL %s: out_o=%b expected %b at %0t", t, out_o, e, $time);
        end
      end
    end
  end

  task automatic step(input bit b, input string tag);
    bit sp, mbyp, e;
    @(negedge clk);
    raw_in = b;
    if (!en) begin
      ms1 = 0; ms2 = 0; mf = 0; mc = 0; e = 0;
    end else begin
      sp   = sync_en ? ms2 : b;
      mbyp = bypass || mode < 3'd4 || flt_len == 0;
      if (mbyp) begin
        mf = sp; mc = 0;
      end else if (mode == 3'd4) begin
        if (mc > 0) mc--;
        else if (sp != mf) begin mf = sp; mc = int'(flt_len); end
      end else begin
        if (sp == mf) mc = 0;
        else if ((mode == 3'd6 && sp) || (mode == 3'd7 && !sp)) begin mf = sp; mc = 0; end
        else begin
          mc++;
          if (mc >= int'(flt_len)) begin mf = sp; mc = 0; end
        end
      end
      ms2 = ms1; ms1 = b;
      e = (mbyp ? (sync_en ? ms2 : b) : mf) ^ invert;
    end
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    -> chk_ev;
    #0;
  endtask

  task automatic seq(input logic [31:0] pat, input int n, input string tag);
    for (int i = 0; i < n; i++) step(pat[i], tag);
  endtask

  task automatic cfg(input bit e, input bit byp, input bit inv, input bit syn,
                     input logic [2:0] m, input int len);
    @(negedge clk);
    en = e; bypass = byp; invert = inv; sync_en = syn; mode = m;
    flt_len = LEN_W'(len);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 0; raw_in = 0; bypass = 0; invert = 0; sync_en = 0;
    mode = 3'b000; flt_len = '0;
    repeat (3) @(posedge clk);
    #1;
    n_run++;
    if (out_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: out_o=%b expected 0", out_o);
    end
    @(negedge clk); rst_n = 1'b1;

    cfg(0, 1, 1, 0, 3'b101, 3);
    seq(32'b1011, 4, "R1 disabled");
    cfg(1, 1, 0, 0, 3'b101, 3);
    seq(32'b0110_1001, 8, "R4 bypass direct");
    cfg(1, 1, 1, 0, 3'b110, 3);
    seq(32'b0011_0101, 8, "R3 invert");
    cfg(1, 1, 0, 1, 3'b100, 3);
    seq(32'b0000_1110_0111, 12, "R2 sync latency");
    cfg(1, 0, 0, 0, 3'b010, 3);
    seq(32'b1010_0110, 8, "R5 reserved mode");
    cfg(1, 0, 0, 0, 3'b000, 3);
    seq(32'b0101_1001, 8, "R5 mode zero");
    cfg(1, 0, 0, 0, 3'b101, 0);
    seq(32'b1001_0110, 8, "R5 length zero");

    cfg(1, 0, 0, 0, 3'b000, 1);
    seq(32'b00, 2, "R6 prep");
    cfg(1, 0, 0, 0, 3'b100, 3);
    seq(32'b0000_0011_0000_0101, 16, "R6 hold-off");
    cfg(1, 0, 0, 1, 3'b100, 1);
    seq(32'b1111_0010_1100_1010, 16, "R6 sync len1");

    cfg(1, 0, 0, 0, 3'b000, 1);
    seq(32'b00, 2, "R7 prep");
    cfg(1, 0, 0, 0, 3'b101, 3);
    seq(32'b0000_0111_1101_1011, 16, "R7 qualified");
    cfg(1, 0, 1, 1, 3'b101, 4);
    seq(32'b0000_0000_1111_1111_0111_1000, 24, "R7 sync inv");

    cfg(1, 0, 0, 0, 3'b000, 1);
    seq(32'b00, 2, "R8 prep");
    cfg(1, 0, 0, 0, 3'b110, 3);
    seq(32'b1110_0011_1001_0101, 16, "R8 qualify low");

    cfg(1, 0, 0, 0, 3'b000, 1);
    seq(32'b11, 2, "R9 prep");
    cfg(1, 0, 0, 0, 3'b111, 3);
    seq(32'b0001_1100_0110_1010, 16, "R9 qualify high");

    cfg(1, 0, 0, 0, 3'b000, 1);
    seq(32'b11, 2, "R1 prep");
    cfg(0, 0, 1, 0, 3'b111, 3);
    seq(32'b111, 3, "R1 drop enable");
    cfg(1, 0, 0, 0, 3'b111, 3);
    seq(32'b0111_1100, 8, "R1 re-enable");

    repeat (2) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule